// File: doc/BRIEF.md
# Six-Operation ALU with Zero Flag

This block is the arithmetic and logic unit for the datapath of a small processor. It has no clock and no state. It takes two operand words and a 3-bit operation selector and returns a result word together with a single zero indicator. The selector picks one of six operations: wrapping addition, wrapping subtraction, bitwise AND, bitwise OR, a one-hot decode of operand A, and an unsigned set-on-less-than comparison. Both spare selector codes give a result of zero.

The zero indicator drives the processor's conditional branches. To test two registers for equality, the control logic selects subtraction and looks at the zero output. One internal adder serves addition, subtraction and the comparison. The comparison reads the adder's borrow, and that borrow is brought out as a named internal wire so the assertions can reach it.

The operand width is a parameter with a default of 16. The decode operation uses the low log2(WIDTH) bits of operand A.

Top module: `alu6_core`

## Requirements
- R1: With op_sel = 3'b000, result equals (opnd_a + opnd_b) modulo 2^16. A carry out of the top bit is discarded and nothing signals it.
- R2: With op_sel = 3'b001, result equals (opnd_a - opnd_b) modulo 2^16. A borrow wraps around and nothing signals it.
- R3: With op_sel = 3'b010, each result bit is the AND of the matching bits of opnd_a and opnd_b.
- R4: With op_sel = 3'b011, each result bit is the OR of the matching bits of opnd_a and opnd_b.
- R5: With op_sel = 3'b100, result has exactly one bit set, at position opnd_a[3:0]. Bits 15:4 of opnd_a and all of opnd_b have no effect.
- R6: With op_sel = 3'b101, result is 16'h0001 when opnd_a is less than opnd_b as unsigned numbers, and 16'h0000 otherwise.
- R7: With op_sel = 3'b110 or 3'b111, result is 16'h0000 for any operands.
- R8: zero is 1 exactly when all 16 result bits are 0, for every op_sel.
- R9: With op_sel = 3'b001, zero is 1 exactly when opnd_a equals opnd_b.
- R10: The outputs depend only on the present inputs. Applying an earlier input set again gives the same result and zero as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation selector: 000 add, 001 subtract, 010 AND, 011 OR, 100 decode, 101 set-on-less, 110/111 zero |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bound checker evaluates every input change. It checks the inverse relations of addition and subtraction, the subset relations of AND and OR, the one-hot shape and position of the decode, the single-bit form of set-on-less and its agreement with the internal borrow, the zero result of the spare codes, and the subtract-based equality test. Only the bench's sweeps can show that the exact values match across wide operand patterns, including the wrap corners at 16'hFFFF and 16'h8000. The sweeps also show that the zero output tracks the result for every operation. Re-applying earlier inputs after other traffic shows that the block keeps no hidden state.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_DEC  = 3'b100,
    OP_SLT  = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } alu_op_e;

  // True when the shared adder must run in subtract mode.
  function automatic logic needs_subtract(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SLT);
  endfunction

  // True for the two spare selector codes.
  function automatic logic is_spare(input alu_op_e op);
    return (op == OP_RSV6) || (op == OP_RSV7);
  endfunction

endpackage

// File: rtl/alu6_addsub.sv
module alu6_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum,
  output logic             below
);
  localparam int EXTW = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic [EXTW-1:0]  total;

  function automatic logic [EXTW-1:0] add_ext(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y,
                                              input logic             cin);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  assign b_eff = sub_mode ? ~in_b : in_b;
  assign total = add_ext(in_a, b_eff, sub_mode);
  assign sum   = total[WIDTH-1:0];
  // In subtract mode a missing carry out means a borrow, so in_a < in_b.
  assign below = sub_mode & ~total[EXTW-1];
endmodule

// File: rtl/alu6_logic.sv
module alu6_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic [WIDTH-1:0] and_out,
  output logic [WIDTH-1:0] or_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign and_out[g] = in_a[g] & in_b[g];
    assign or_out[g]  = in_a[g] | in_b[g];
  end
endmodule

// File: rtl/alu6_decode.sv
module alu6_decode #(
  parameter int WIDTH = 16,
  parameter int SELW  = $clog2(WIDTH)
) (
  input  logic [SELW-1:0]  idx,
  output logic [WIDTH-1:0] onehot
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    assign onehot[g] = (idx == SELW'(g));
  end
endmodule

// File: rtl/alu6_core.sv
module alu6_core #(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  import alu6_pkg::*;

  localparam int SELW = $clog2(WIDTH);

  alu_op_e          op;
  logic             sub_mode;
  logic [WIDTH-1:0] arith_sum;
  logic             cmp_lt;
  logic [WIDTH-1:0] and_word;
  logic [WIDTH-1:0] or_word;
  logic [WIDTH-1:0] dec_word;
  logic [WIDTH-1:0] slt_word;

  assign op       = alu_op_e'(op_sel);
  assign sub_mode = needs_subtract(op);

  alu6_addsub #(.WIDTH(WIDTH)) u_add (
    .in_a     (opnd_a),
    .in_b     (opnd_b),
    .sub_mode (sub_mode),
    .sum      (arith_sum),
    .below    (cmp_lt)
  );

  alu6_logic #(.WIDTH(WIDTH)) u_logic (
    .in_a    (opnd_a),
    .in_b    (opnd_b),
    .and_out (and_word),
    .or_out  (or_word)
  );

  alu6_decode #(.WIDTH(WIDTH), .SELW(SELW)) u_dec (
    .idx    (opnd_a[SELW-1:0]),
    .onehot (dec_word)
  );

  assign slt_word = {{(WIDTH-1){1'b0}}, cmp_lt};

  always_comb begin
    unique case (op)
      OP_ADD,
      OP_SUB:  result = arith_sum;
      OP_AND:  result = and_word;
      OP_OR:   result = or_word;
      OP_DEC:  result = dec_word;
      OP_SLT:  result = slt_word;
      default: result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/alu6_checks.sv
module alu6_checks #(
  parameter int WIDTH = 16
) (
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             cmp_lt
);
  localparam int SELW = $clog2(WIDTH);

  always_comb begin
    if (op_sel == 3'b000)
      assert_add_inverse_R1: assert (WIDTH'(result - opnd_b) == opnd_a);
    if (op_sel == 3'b001)
      assert_sub_inverse_R2: assert (WIDTH'(result + opnd_b) == opnd_a);
    if (op_sel == 3'b010)
      assert_and_subset_R3: assert (((result & ~opnd_a) == '0) &&
                                    ((result & ~opnd_b) == '0) &&
                                    ((opnd_a & opnd_b & ~result) == '0));
    if (op_sel == 3'b011)
      assert_or_cover_R4: assert (((opnd_a & ~result) == '0) &&
                                  ((opnd_b & ~result) == '0) &&
                                  ((result & ~opnd_a & ~opnd_b) == '0));
    if (op_sel == 3'b100)
      assert_decode_onehot_R5: assert (($countones(result) == 1) &&
                                       result[opnd_a[SELW-1:0]]);
    if (op_sel == 3'b101)
      assert_slt_single_bit_R6: assert ((result[WIDTH-1:1] == '0) &&
                                        (result[0] == cmp_lt) &&
                                        (cmp_lt == (opnd_a < opnd_b)));
    if (op_sel[2:1] == 2'b11)
      assert_spare_zero_R7: assert ((result == '0) && zero);
    if (op_sel == 3'b001)
      assert_equal_test_R9: assert (zero == (opnd_a == opnd_b));
  end
endmodule

bind alu6_core alu6_checks #(.WIDTH(WIDTH)) u_checks (
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .result (result),
  .zero   (zero),
  .cmp_lt (cmp_lt)
);

// File: tb/tb_alu6_core.sv
module tb_alu6_core;
  logic        clk = 1'b0;
  logic [2:0]  op_sel = 3'b000;
  logic [15:0] opnd_a = 16'h0000;
  logic [15:0] opnd_b = 16'h0000;
  logic [15:0] result;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  alu6_core #(.WIDTH(16)) dut (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .zero   (zero)
  );

  function automatic logic [15:0] pattern(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      4: return 16'h7FFF;
      5: return 16'h0002;
      6: return 16'hFFFE;
      7: return 16'h5555;
      default: return 16'((i * 40503) ^ (i << 9) ^ (i * 7));
    endcase
  endfunction

  function automatic int expect_val(input int op, input int ua, input int ub);
    int e;
    e = 0;
    case (op)
      0: e = (ua + ub) % 65536;
      1: e = (ua - ub + 65536) % 65536;
      2: for (int k = 0; k < 16; k++)
           if (((ua >> k) & 1) == 1 && ((ub >> k) & 1) == 1) e += (1 << k);
      3: for (int k = 0; k < 16; k++)
           if (((ua >> k) & 1) == 1 || ((ub >> k) & 1) == 1) e += (1 << k);
      4: e = 1 << (ua % 16);
      5: e = (ua < ub) ? 1 : 0;
      default: e = 0;
    endcase
    return e;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply_check(input int op, input logic [15:0] a, input logic [15:0] b,
                             input string tag);
    int e;
    @(posedge clk);
    op_sel = 3'(op);
    opnd_a = a;
    opnd_b = b;
    @(negedge clk);
    e = expect_val(op, int'(a), int'(b));
    n_checks++;
    if (int'(result) != e || zero != (e == 0)) begin
      n_fail++;
      $display("FAIL %s (and R8) op=%0d a=%h b=%h: result=%h zero=%0b expected result=%h zero=%0b",
               tag, op, a, b, result, zero, 16'(e), (e == 0));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] keep_res;
    logic        keep_zero;
    // Idle state: all-zero inputs select add of zeros (R1, R8).
    @(negedge clk);
    n_checks++;
    if (result !== 16'h0000 || zero !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 idle: result=%h zero=%0b expected result=0000 zero=1", result, zero);
    end

    // Sweep of every selector code over 64x64 operand patterns (R1..R8).
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 64; j++)
          apply_check(op, pattern(i), pattern(j), tag_of(op));

    // R5: upper bits of A and all of B have no effect on decode.
    for (int s = 0; s < 16; s++)
      apply_check(4, 16'(s) | 16'hABC0, 16'h1234 + 16'(s), "R5");

    // R6 unsigned: a large value is not less than a small one.
    apply_check(5, 16'h8000, 16'h0001, "R6");
    apply_check(5, 16'h0001, 16'h8000, "R6");
    apply_check(5, 16'hFFFF, 16'hFFFF, "R6");

    // R1/R2 wrap corners.
    apply_check(0, 16'hFFFF, 16'h0001, "R1");
    apply_check(1, 16'h0000, 16'h0001, "R2");

    // R9: subtract-based equality on equal and unequal pairs.
    for (int i = 0; i < 64; i++) begin
      apply_check(1, pattern(i), pattern(i), "R9");
      apply_check(1, pattern(i), pattern(i) ^ 16'h0100, "R9");
    end

    // R10: repeat an earlier input after other traffic.
    apply_check(3, 16'h0F0F, 16'h3300, "R10");
    keep_res  = result;
    keep_zero = zero;
    apply_check(0, 16'h1234, 16'h4321, "R10");
    apply_check(3, 16'h0F0F, 16'h3300, "R10");
    n_checks++;
    if (result !== keep_res || zero !== keep_zero) begin
      n_fail++;
      $display("FAIL R10 repeat: result=%h zero=%0b expected result=%h zero=%0b",
               result, zero, keep_res, keep_zero);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule